// File: doc/BRIEF.md
# Flash Programming Command Decoder

This block is the controller that sits between a set of programming pins and a byte-wide code store. While the mode-entry pins are in their programming pattern, it takes command bytes from the data port on the rising edge of a command strobe. It keeps a one-shot flag that allows exactly one program, lock or erase operation. The address and data are captured on the falling edge of a program pulse, and the operation is carried out on the rising edge. The command also selects what the read port returns: the stored byte under one of three verify tags, or a fixed signature byte.

Three lock bits give layered protection. The first blocks further programming. The first two together also block array read-back. All three together also raise an output that forbids execution from external memory. Only a full chip erase restores the array to all-ones and clears the lock bits. All pins are sampled on the block clock, and edges are found by comparing each sample with the one before. The store holds 2^ARR_AW bytes. Program addresses use the low ARR_AW bits, so higher addresses fold onto the same bytes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Command strobes and program pulses act only while rst_pin=1, pstore_n=0, ctl_a=1 and ctl_b=1. Outside that pattern, dout is 00H.
- R2: A command byte is the value on din in the last clock the strobe was sampled low. It is taken when cmd_stb_n is first sampled high again, and changes to din at or after that point have no effect.
- R3: After synchronous reset the read mode is normal verify, no operation is armed, every stored byte reads FFH, all lock bits are unprogrammed and ext_exec_inh is 0.
- R4: A program operation has two cycles: command 40H, then a program pulse. Address and data are taken when prog_n is first sampled low. When prog_n is sampled high again, the addressed byte becomes its old value AND the data. Address and data changes after the fall are ignored.
- R5: Every program-pulse rising edge clears the armed flag. A second pulse with no new 40H command writes nothing.
- R6: Command 00H selects normal verify, C0H selects program verify and A0H selects erase verify. Each returns the stored byte at address bits [ARR_AW-1:0].
- R7: Command 90H selects signature read: 030H gives D5H, 031H gives 52H, and 032H gives AAH when HV_VARIANT=1 or 55H otherwise. Any other 13-bit address gives 00H.
- R8: Commands 60H, 70H and 80H arm lock bit 1, 2 and 3. A following pulse whose captured data is D0H programs that bit. The pulse's rising edge returns the read mode to normal verify whether or not D0H was present.
- R9: With lock bit 1 programmed, program operations leave the store unchanged.
- R10: With lock bits 1 and 2 programmed, array reads in every verify mode return 00H, while signature reads still work.
- R11: ext_exec_inh is 1 exactly when all three lock bits are programmed.
- R12: Command 20H followed by a pulse with D0H sets every byte to FFH, unprograms all lock bits and returns the read mode to normal verify.
- R13: dout is 00H whenever oe_n is 1.
- R14: Any command byte not listed above clears the armed flag and leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset (power-up state) |
| rst_pin | input | 1 | Mode-entry pin, must be high |
| pstore_n | input | 1 | Mode-entry pin, must be low |
| ctl_a | input | 1 | Mode-entry control pin, must be high |
| ctl_b | input | 1 | Mode-entry control pin, must be high |
| cmd_stb_n | input | 1 | Command strobe, active low, byte taken on its rise |
| oe_n | input | 1 | Read output enable, active low |
| prog_n | input | 1 | Program pulse, active low |
| din | input | 8 | Command and program data |
| addr | input | 13 | Byte address |
| dout | output | 8 | Read data, 00H when idle |
| ext_exec_inh | output | 1 | High when external execution is forbidden |

## Verification
The hardest state to reach from the pins is the one where verify is blocked but signature reads still answer. The bench reaches it with a full ordered sequence. It first programs every byte in two passes, the second using folded addresses. It then sends a lock command without the confirm byte, then locks bits 1 and 2 with confirm pulses. Before the lock bits are set, the store holds known nonzero bytes, so a 00H read afterwards can only come from the protection. Each pulse also changes the address and data while prog_n is still low, which shows that only the values at the fall are used.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 13;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // read-out mode tags; margin voltages reduce to labels here
    typedef enum logic [1:0] {
        RM_NORMAL = 2'd0,
        RM_SIG    = 2'd1,
        RM_PVFY   = 2'd2,
        RM_EVFY   = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_LOCK1 = 3'd2,
        OP_LOCK2 = 3'd3,
        OP_LOCK3 = 3'd4,
        OP_ERASE = 3'd5
    } op_e;

    localparam byte_t CMD_NVFY    = 8'h00;
    localparam byte_t CMD_SIG     = 8'h90;
    localparam byte_t CMD_PROG    = 8'h40;
    localparam byte_t CMD_PVFY    = 8'hC0;
    localparam byte_t CMD_LK1     = 8'h60;
    localparam byte_t CMD_LK2     = 8'h70;
    localparam byte_t CMD_LK3     = 8'h80;
    localparam byte_t CMD_ERASE   = 8'h20;
    localparam byte_t CMD_EVFY    = 8'hA0;
    localparam byte_t CMD_CONFIRM = 8'hD0;

    localparam byte_t ERASED_BYTE = 8'hFF;

    typedef struct packed {
        logic   is_read;
        rmode_e rmode;
        op_e    op;
    } cmd_dec_t;

    // lock bits: 1 = unprogrammed (erased), 0 = programmed
    typedef struct packed {
        logic lb3;
        logic lb2;
        logic lb1;
    } lock_t;

    typedef struct packed {
        logic prog_dis;
        logic vfy_dis;
        logic ext_inh;
    } lock_pol_t;

    function automatic cmd_dec_t decode_cmd(input byte_t c);
        cmd_dec_t r;
        r.is_read = 1'b0;
        r.rmode   = RM_NORMAL;
        r.op      = OP_NONE;
        case (c)
            CMD_NVFY:  begin r.is_read = 1'b1; r.rmode = RM_NORMAL; end
            CMD_SIG:   begin r.is_read = 1'b1; r.rmode = RM_SIG;    end
            CMD_PVFY:  begin r.is_read = 1'b1; r.rmode = RM_PVFY;   end
            CMD_EVFY:  begin r.is_read = 1'b1; r.rmode = RM_EVFY;   end
            CMD_PROG:  r.op = OP_PROG;
            CMD_LK1:   r.op = OP_LOCK1;
            CMD_LK2:   r.op = OP_LOCK2;
            CMD_LK3:   r.op = OP_LOCK3;
            CMD_ERASE: r.op = OP_ERASE;
            default:   r.op = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic needs_confirm(input op_e op);
        return (op == OP_LOCK1) || (op == OP_LOCK2) ||
               (op == OP_LOCK3) || (op == OP_ERASE);
    endfunction

    function automatic lock_pol_t lock_policy(input lock_t lk);
        lock_pol_t p;
        p.prog_dis = ~lk.lb1;
        p.vfy_dis  = ~lk.lb1 & ~lk.lb2;
        p.ext_inh  = ~lk.lb1 & ~lk.lb2 & ~lk.lb3;
        return p;
    endfunction

    function automatic byte_t sig_byte(input addr_t a, input logic hv);
        byte_t r;
        case (a)
            13'h030: r = 8'hD5;
            13'h031: r = 8'h52;
            13'h032: r = hv ? 8'hAA : 8'h55;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fcd_edge.sv
module fcd_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    for (genvar gi = 0; gi < N; gi++) begin : g_pin
        always_ff @(posedge clk) begin
            prev[gi] <= sig[gi];
        end
        assign rise[gi] = sig[gi] & ~prev[gi];
        assign fall[gi] = ~sig[gi] & prev[gi];
    end
endmodule

// File: rtl/fcd_cmd_decode.sv
module fcd_cmd_decode
    import fcd_pkg::*;
#(
    parameter int ARR_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_ok,
    input  logic              cmd_stb_n,
    input  logic              stb_rise,
    input  logic              prog_fall,
    input  logic              prog_rise,
    input  byte_t             din,
    input  logic [ARR_AW-1:0] addr_lo,
    output rmode_e            rmode,
    output op_e               op,
    output logic              commit,
    output logic [ARR_AW-1:0] wr_idx,
    output byte_t             wr_data
);
    byte_t             cmd_q;
    cmd_dec_t          dec;
    logic [ARR_AW-1:0] lat_idx;
    byte_t             lat_data;
    logic              confirm_ok;

    assign dec        = decode_cmd(cmd_q);
    assign confirm_ok = (op == OP_PROG) || (lat_data == CMD_CONFIRM);
    assign commit     = mode_ok && prog_rise && (op != OP_NONE) && confirm_ok;
    assign wr_idx     = lat_idx;
    assign wr_data    = lat_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            rmode    <= RM_NORMAL;
            op       <= OP_NONE;
            lat_idx  <= '0;
            lat_data <= '0;
        end else begin
            // track the byte present while the strobe is low
            if (!cmd_stb_n) begin
                cmd_q <= din;
            end
            if (mode_ok) begin
                if (prog_fall) begin
                    lat_idx  <= addr_lo;
                    lat_data <= din;
                end
                if (prog_rise) begin
                    op <= OP_NONE;
                    if (needs_confirm(op)) begin
                        rmode <= RM_NORMAL;
                    end
                end
                // a new command wins over a pulse edge in the same cycle
                if (stb_rise) begin
                    op <= dec.op;
                    if (dec.is_read) begin
                        rmode <= dec.rmode;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fcd_array.sv
module fcd_array
    import fcd_pkg::*;
#(
    parameter int ARR_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  op_e               op,
    input  logic [ARR_AW-1:0] wr_idx,
    input  byte_t             wr_data,
    input  logic [ARR_AW-1:0] rd_idx,
    output byte_t             rd_data,
    output lock_t             locks
);
    localparam int DEPTH = 1 << ARR_AW;

    byte_t mem [DEPTH];
    logic  prog_blocked;

    assign prog_blocked = lock_policy(locks).prog_dis;
    assign rd_data      = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ERASED_BYTE;
            end
            locks <= 3'b111;
        end else if (commit) begin
            case (op)
                OP_PROG: begin
                    if (!prog_blocked) begin
                        mem[wr_idx] <= mem[wr_idx] & wr_data;
                    end
                end
                OP_LOCK1: locks.lb1 <= 1'b0;
                OP_LOCK2: locks.lb2 <= 1'b0;
                OP_LOCK3: locks.lb3 <= 1'b0;
                OP_ERASE: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= ERASED_BYTE;
                    end
                    locks <= 3'b111;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fcd_read_path.sv
module fcd_read_path
    import fcd_pkg::*;
#(
    parameter bit    HV_VARIANT = 1'b1,
    parameter byte_t IDLE_BYTE  = 8'h00
) (
    input  logic   mode_ok,
    input  logic   oe_n,
    input  rmode_e rmode,
    input  addr_t  addr,
    input  byte_t  arr_data,
    input  lock_t  locks,
    output byte_t  dout
);
    byte_t sel;
    logic  vfy_blocked;

    assign vfy_blocked = lock_policy(locks).vfy_dis;

    always_comb begin
        if (rmode == RM_SIG) begin
            sel = sig_byte(addr, HV_VARIANT);
        end else if (vfy_blocked) begin
            sel = IDLE_BYTE;
        end else begin
            sel = arr_data;
        end
        dout = (mode_ok && !oe_n) ? sel : IDLE_BYTE;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcd_pkg::*;
#(
    parameter int    ARR_AW     = 8,
    parameter bit    HV_VARIANT = 1'b1,
    parameter byte_t IDLE_BYTE  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rst_pin,
    input  logic        pstore_n,
    input  logic        ctl_a,
    input  logic        ctl_b,
    input  logic        cmd_stb_n,
    input  logic        oe_n,
    input  logic        prog_n,
    input  logic [7:0]  din,
    input  logic [12:0] addr,
    output logic [7:0]  dout,
    output logic        ext_exec_inh
);
    localparam int N_EDGE = 2;
    localparam int E_STB  = 0;
    localparam int E_PROG = 1;

    logic              mode_ok;
    logic [N_EDGE-1:0] rise;
    logic [N_EDGE-1:0] fall;
    rmode_e            rmode;
    op_e               op;
    logic              commit;
    logic [ARR_AW-1:0] wr_idx;
    byte_t             wr_data;
    byte_t             arr_data;
    lock_t             locks;

    assign mode_ok      = rst_pin && !pstore_n && ctl_a && ctl_b;
    assign ext_exec_inh = lock_policy(locks).ext_inh;

    fcd_edge #(.N(N_EDGE)) u_edge (
        .clk  (clk),
        .sig  ({prog_n, cmd_stb_n}),
        .rise (rise),
        .fall (fall)
    );

    fcd_cmd_decode #(.ARR_AW(ARR_AW)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .mode_ok   (mode_ok),
        .cmd_stb_n (cmd_stb_n),
        .stb_rise  (rise[E_STB]),
        .prog_fall (fall[E_PROG]),
        .prog_rise (rise[E_PROG]),
        .din       (din),
        .addr_lo   (addr[ARR_AW-1:0]),
        .rmode     (rmode),
        .op        (op),
        .commit    (commit),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    fcd_array #(.ARR_AW(ARR_AW)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .op      (op),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (addr[ARR_AW-1:0]),
        .rd_data (arr_data),
        .locks   (locks)
    );

    fcd_read_path #(.HV_VARIANT(HV_VARIANT), .IDLE_BYTE(IDLE_BYTE)) u_rd (
        .mode_ok  (mode_ok),
        .oe_n     (oe_n),
        .rmode    (rmode),
        .addr     (addr),
        .arr_data (arr_data),
        .locks    (locks),
        .dout     (dout)
    );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import fcd_pkg::*;
#(
    parameter byte_t IDLE_BYTE = 8'h00
) (
    input logic   clk,
    input logic   rst,
    input logic   mode_ok,
    input logic   cmd_stb_n,
    input logic   prog_n,
    input logic   oe_n,
    input addr_t  addr,
    input byte_t  dout,
    input rmode_e rmode,
    input op_e    op,
    input lock_t  locks
);
    p_idle_out_r13: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> dout == IDLE_BYTE);

    p_gate_r1: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |-> dout == IDLE_BYTE);

    p_reset_state_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rmode == RM_NORMAL && op == OP_NONE && locks == 3'b111));

    p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && $rose(prog_n) && !$rose(cmd_stb_n)) |=> op == OP_NONE);

    p_lock_to_normal_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && $rose(prog_n) && !$rose(cmd_stb_n) &&
         (op == OP_LOCK1 || op == OP_LOCK2 || op == OP_LOCK3 || op == OP_ERASE))
        |=> rmode == RM_NORMAL);

    p_sig_first_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && !oe_n && rmode == RM_SIG && addr == 13'h030) |-> dout == 8'hD5);

    p_vfy_block_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && !oe_n && rmode != RM_SIG && !locks.lb1 && !locks.lb2)
        |-> dout == IDLE_BYTE);

    p_unlock_erase_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(locks.lb1) |-> $past(op) == OP_ERASE);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.IDLE_BYTE(IDLE_BYTE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_ok   (mode_ok),
    .cmd_stb_n (cmd_stb_n),
    .prog_n    (prog_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .dout      (dout),
    .rmode     (rmode),
    .op        (op),
    .locks     (locks)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_pin = 1'b1;
    logic        pstore_n = 1'b0;
    logic        ctl_a = 1'b1;
    logic        ctl_b = 1'b1;
    logic        cmd_stb_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        prog_n = 1'b1;
    logic [7:0]  din = 8'h00;
    logic [12:0] addr = 13'h0;
    logic [7:0]  dout;
    logic        ext_exec_inh;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] model [256];
    logic [7:0] rv;

    always #5 clk = ~clk;

    flash_cmd_ctrl u0 (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .pstore_n(pstore_n),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .cmd_stb_n(cmd_stb_n), .oe_n(oe_n),
        .prog_n(prog_n), .din(din), .addr(addr), .dout(dout),
        .ext_exec_inh(ext_exec_inh)
    );

    function automatic logic [7:0] pat_a(input int a);
        return 8'(a * 37 + 11);
    endfunction

    function automatic logic [7:0] pat_b(input int a);
        return ~8'(a);
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        din = c;
        cmd_stb_n = 1'b0;
        cyc(2);
        cmd_stb_n = 1'b1;
        cyc(2);
    endtask

    // byte changes in the same step the strobe rises
    task automatic send_cmd_skew(input logic [7:0] c, input logic [7:0] junk);
        @(negedge clk);
        din = c;
        cmd_stb_n = 1'b0;
        cyc(2);
        cmd_stb_n = 1'b1;
        din = junk;
        cyc(2);
    endtask

    // address and data are disturbed while prog_n is still low
    task automatic pulse(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        din = d;
        cyc(1);
        prog_n = 1'b0;
        cyc(2);
        addr = ~a;
        din = ~d;
        cyc(1);
        prog_n = 1'b1;
        cyc(2);
    endtask

    task automatic read_at(input logic [12:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        oe_n = 1'b0;
        cyc(1);
        v = dout;
        oe_n = 1'b1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        cyc(5);
        rst = 1'b0;
        cyc(2);

        // R3 / R13: reset state
        check8("R13 idle with oe_n high", dout, 8'h00);
        check8("R3 ext_exec_inh after reset", {7'd0, ext_exec_inh}, 8'h00);
        for (int a = 0; a < 256; a++) begin
            read_at(13'(a), rv);
            check8("R3 erased array after reset", rv, 8'hFF);
        end

        // R1: commands ignored outside the entry pattern
        ctl_a = 1'b0;
        send_cmd(8'h40);
        pulse(13'd5, 8'h00);
        read_at(13'd5, rv);
        check8("R1 read gated while ctl_a low", rv, 8'h00);
        ctl_a = 1'b1;
        read_at(13'd5, rv);
        check8("R1 no write while ctl_a low", rv, 8'hFF);
        pstore_n = 1'b1;
        read_at(13'd5, rv);
        check8("R1 read gated while pstore_n high", rv, 8'h00);
        pstore_n = 1'b0;

        // R2 / R7: byte from the low phase, signature bytes
        send_cmd_skew(8'h90, 8'h40);
        read_at(13'h030, rv);
        check8("R2 byte held during strobe low used", rv, 8'hD5);
        read_at(13'h031, rv);
        check8("R7 signature 031", rv, 8'h52);
        read_at(13'h032, rv);
        check8("R7 signature 032 high-voltage", rv, 8'hAA);
        read_at(13'h033, rv);
        check8("R7 signature other address", rv, 8'h00);
        read_at(13'h1030, rv);
        check8("R7 signature upper address bits", rv, 8'h00);

        // R4 / R6: first program pass, normal verify sweep
        for (int a = 0; a < 256; a++) begin
            send_cmd(8'h40);
            pulse(13'(a), pat_a(a));
            model[a] = model[a] & pat_a(a);
        end
        send_cmd(8'h00);
        for (int a = 0; a < 256; a++) begin
            read_at(13'(a), rv);
            check8("R4 program pass one", rv, model[a]);
        end

        // R5: one-shot flag
        send_cmd(8'h40);
        pulse(13'd10, 8'h00);
        model[10] = 8'h00;
        pulse(13'd11, 8'h00);
        read_at(13'd10, rv);
        check8("R5 armed pulse writes", rv, model[10]);
        read_at(13'd11, rv);
        check8("R5 second pulse without command", rv, model[11]);

        // R4 / R6: second pass through folded addresses, program verify sweep
        for (int a = 0; a < 256; a++) begin
            send_cmd(8'h40);
            pulse(13'(a) | 13'h1F00, pat_b(a));
            model[a] = model[a] & pat_b(a);
        end
        send_cmd(8'hC0);
        for (int a = 0; a < 256; a++) begin
            read_at(13'(a), rv);
            check8("R6 program verify after folded pass", rv, model[a]);
        end
        send_cmd(8'hA0);
        for (int a = 0; a < 256; a += 17) begin
            read_at(13'(a) | 13'h0A00, rv);
            check8("R6 erase verify folded read", rv, model[a]);
        end

        // R14: unknown command disarms and keeps read mode
        send_cmd(8'h90);
        send_cmd(8'h40);
        send_cmd(8'h33);
        pulse(13'd5, 8'h00);
        read_at(13'h030, rv);
        check8("R14 read mode kept after unknown", rv, 8'hD5);
        send_cmd(8'h00);
        read_at(13'd5, rv);
        check8("R14 unknown command disarmed", rv, model[5]);

        // R8: lock without confirm byte programs nothing
        send_cmd(8'h60);
        pulse(13'd0, 8'h12);
        send_cmd(8'h40);
        pulse(13'd1, 8'h00);
        model[1] = 8'h00;
        read_at(13'd1, rv);
        check8("R8 lock without confirm leaves programming open", rv, model[1]);

        // R8 / R9: lock bit 1
        send_cmd(8'h90);
        send_cmd(8'h60);
        pulse(13'd0, 8'hD0);
        read_at(13'd0, rv);
        check8("R8 lock pulse returns to normal verify", rv, model[0]);
        send_cmd(8'h40);
        pulse(13'd2, 8'h00);
        read_at(13'd2, rv);
        check8("R9 program blocked by lock bit 1", rv, model[2]);

        // R10: lock bit 2
        send_cmd(8'h70);
        pulse(13'd0, 8'hD0);
        read_at(13'd3, rv);
        check8("R10 normal verify blocked", rv, 8'h00);
        send_cmd(8'hC0);
        read_at(13'd3, rv);
        check8("R10 program verify blocked", rv, 8'h00);
        send_cmd(8'h90);
        read_at(13'h031, rv);
        check8("R10 signature still readable", rv, 8'h52);
        check8("R11 inhibit low with two lock bits", {7'd0, ext_exec_inh}, 8'h00);

        // R11: lock bit 3
        send_cmd(8'h80);
        pulse(13'd0, 8'hD0);
        check8("R11 inhibit high with three lock bits", {7'd0, ext_exec_inh}, 8'h01);

        // R12: chip erase
        send_cmd(8'h90);
        send_cmd(8'h20);
        pulse(13'd0, 8'hD0);
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        read_at(13'h030, rv);
        check8("R12 erase returns to normal verify", rv, 8'hFF);
        for (int a = 0; a < 256; a++) begin
            read_at(13'(a), rv);
            check8("R12 erased array", rv, 8'hFF);
        end
        check8("R12 locks cleared by erase", {7'd0, ext_exec_inh}, 8'h00);
        send_cmd(8'h40);
        pulse(13'd7, 8'h3C);
        read_at(13'd7, rv);
        check8("R12 programming reopened", rv, 8'h3C);
        addr = 13'd7;
        cyc(1);
        check8("R13 idle while oe_n high", dout, 8'h00);

        summary();
        $finish;
    end
endmodule